// File: doc/BRIEF.md
# Input Change Notification Controller

This block watches a set of input pins and raises a sticky interrupt request whenever a pin that software has enabled changes level. Rising and falling transitions both count. Each pin has its own enable bit and its own weak pull-up control bit. Both sets of bits sit in a small register file reached over a simple single-cycle register bus. The pull-up controls drive the pads directly. A pad that is currently an output always has its pull-up forced off.

In normal operation the pins pass through a two-flop synchronizer. Each synchronized value is compared against the value captured on the previous cycle. The block also works while the system clock is stopped in a low-power state. In that state an asynchronous comparison of the live pins against the last captured values drives a wake output, with no clock needed. On the first clock edge after the clock resumes, the interrupt flag is set.

Top module: `chg_notify`

## Requirements
- R1: After reset, irq_o and wake_o are 0, pu_o is all zero, and every register reads 0.
- R2: Register map over the bus, with combinational read data:
  - Address 0 holds the enables for pins 15..0 in bits 15..0.
  - Address 1 holds the enables for pins 20..16 in bits 4..0.
  - Addresses 2 and 3 hold the pull-up enables in the same layout.
  - Address 4 holds the interrupt flag in bit 0.
  - Bits that are not implemented read 0.
- R3: A rising level on an enabled pin, applied between clock edges, sets irq_o at the third rising clock edge after the change.
- R4: A falling level on an enabled pin sets irq_o with the same latency as R3.
- R5: Changes on pins whose enable bit is 0 never set irq_o. Enabling a pin whose level changed earlier raises no flag, because the captured value tracks every pin whether or not it is enabled.
- R6: irq_o stays set until a write to address 4 with bit 0 equal to 1. Writing 0 there leaves it set.
- R7: When a change is detected in the same cycle as a clearing write, the flag stays set.
- R8: Each bit of pu_o equals that pin's pull-up enable AND NOT its pin_is_out bit.
- R9: With sleep_mode at 1, wake_o rises without any clock edge when an enabled pin differs from its last captured value. A difference on a disabled pin leaves wake_o at 0.
- R10: While sleep_mode is 1, the captured values are held. At the first clock edge that sees wake_o at 1, irq_o is set, and wake_o stays high until sleep is left.
- R11: wake_o is 0 whenever sleep_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, may be stopped during sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 21 | Live pin levels |
| pin_is_out | input | 21 | 1 where the pin is driven as an output |
| sleep_mode | input | 1 | Low-power state active |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pu_o | output | 21 | Weak pull-up enables to the pads |
| irq_o | output | 1 | Sticky change interrupt request |
| wake_o | output | 1 | Asynchronous wake request during sleep |

## Verification
The pin-pattern table tries the following cases, each with a different enable mask:
- single-pin rising and falling steps;
- a change confined to a disabled pin;
- wide multi-pin flips where the enabled pins either stay put or toggle;
- a full-mask return to zero.

Together these separate true edge detection from level detection, and from ignoring the mask. Directed tests then cover the following:
- the exact three-edge latency;
- a clear colliding with a fresh change;
- a zero written to the status bit;
- pull-up gating by direction;
- the stopped-clock path, where an enabled pin must raise wake with no edge and a disabled one must not.

// File: rtl/cn_pkg.sv
package cn_pkg;

  typedef enum logic [2:0] {
    CN_EN_LO = 3'd0,
    CN_EN_HI = 3'd1,
    CN_PU_LO = 3'd2,
    CN_PU_HI = 3'd3,
    CN_STAT  = 3'd4
  } cn_reg_e;

  // pins that moved since last capture and are enabled
  function automatic logic [31:0] cn_changed(logic [31:0] cur, logic [31:0] prev,
                                            logic [31:0] en);
    return (cur ^ prev) & en;
  endfunction

  // pull-up request gated off for pads acting as outputs
  function automatic logic [31:0] cn_pull_gate(logic [31:0] pu_en, logic [31:0] is_out);
    return pu_en & ~is_out;
  endfunction

  // next state of the sticky flag: a set event beats a clear
  function automatic logic cn_flag_next(logic flag, logic set_ev, logic clr_ev);
    return set_ev | (flag & ~clr_ev);
  endfunction

endpackage

// File: rtl/cn_sync.sv
module cn_sync #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[g] <= 1'b0;
        q_o[g]  <= 1'b0;
      end else begin
        meta[g] <= d_i[g];
        q_o[g]  <= meta[g];
      end
    end
  end
endmodule

// File: rtl/cn_regs.sv
module cn_regs
  import cn_pkg::*;
#(
  parameter int NUM_PINS = 21,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                flag_i,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] pu_en_o,
  output logic                clr_o
);
  localparam int LO_W = DATA_W;
  localparam int HI_W = NUM_PINS - LO_W;

  logic wr_en;
  assign wr_en = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o    <= '0;
      pu_en_o <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        CN_EN_LO: en_o[LO_W-1:0]           <= bus_wdata;
        CN_EN_HI: en_o[NUM_PINS-1:LO_W]    <= bus_wdata[HI_W-1:0];
        CN_PU_LO: pu_en_o[LO_W-1:0]        <= bus_wdata;
        CN_PU_HI: pu_en_o[NUM_PINS-1:LO_W] <= bus_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = wr_en && (bus_addr == CN_STAT) && bus_wdata[0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      CN_EN_LO: bus_rdata = en_o[LO_W-1:0];
      CN_EN_HI: bus_rdata[HI_W-1:0] = en_o[NUM_PINS-1:LO_W];
      CN_PU_LO: bus_rdata = pu_en_o[LO_W-1:0];
      CN_PU_HI: bus_rdata[HI_W-1:0] = pu_en_o[NUM_PINS-1:LO_W];
      CN_STAT:  bus_rdata[0] = flag_i;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cn_detect.sv
module cn_detect
  import cn_pkg::*;
#(
  parameter int NUM_PINS = 21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] en,
  input  logic                sleep_mode,
  input  logic                clr,
  output logic                chg_any,
  output logic                wake_set,
  output logic                wake_o,
  output logic                flag_o
);
  logic [NUM_PINS-1:0] prev;
  logic [NUM_PINS-1:0] chg_vec;
  logic [NUM_PINS-1:0] async_vec;

  // captured value tracks all pins; frozen while asleep
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           prev <= '0;
    else if (!sleep_mode) prev <= pin_sync;
  end

  assign chg_vec   = NUM_PINS'(cn_changed(32'(pin_sync), 32'(prev), 32'(en)));
  assign chg_any   = |chg_vec;
  assign async_vec = NUM_PINS'(cn_changed(32'(pin_raw), 32'(prev), 32'(en)));
  assign wake_o    = sleep_mode & (|async_vec);
  assign wake_set  = wake_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= cn_flag_next(flag_o, chg_any | wake_set, clr);
  end
endmodule

// File: rtl/chg_notify.sv
module chg_notify
  import cn_pkg::*;
#(
  parameter int NUM_PINS = 21,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_is_out,
  input  logic                sleep_mode,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [2:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] pu_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] en;
  logic [NUM_PINS-1:0] pu_en;
  logic                clr;
  logic                chg_any;
  logic                wake_set;
  logic                flag;

  cn_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cn_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_i(flag), .en_o(en), .pu_en_o(pu_en), .clr_o(clr)
  );

  cn_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_i), .pin_sync(pin_sync), .en(en),
    .sleep_mode(sleep_mode), .clr(clr), .chg_any(chg_any), .wake_set(wake_set),
    .wake_o(wake_o), .flag_o(flag)
  );

  assign pu_o  = NUM_PINS'(cn_pull_gate(32'(pu_en), 32'(pin_is_out)));
  assign irq_o = flag;
endmodule

// File: rtl/cn_chk.sv
module cn_chk #(
  parameter int NUM_PINS = 21
) (
  input logic                clk,
  input logic                rst_n,
  input logic                chg_any,
  input logic                wake_set,
  input logic                clr,
  input logic                sleep_mode,
  input logic                irq_o,
  input logic                wake_o,
  input logic [NUM_PINS-1:0] pu_o,
  input logic [NUM_PINS-1:0] pin_is_out
);
  // R3
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_any |=> irq_o);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr) |=> irq_o);
  // R6
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chg_any && !wake_set) |=> !irq_o);
  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && chg_any) |=> irq_o);
  // R5
  no_spurious_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !chg_any && !wake_set) |=> !irq_o);
  // R8
  pullup_off_for_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_o & pin_is_out) == '0);
  // R11
  wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_mode |-> !wake_o);
  // R10
  wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_mode && wake_o) |=> irq_o);
endmodule

bind chg_notify cn_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chg_any(chg_any), .wake_set(wake_set), .clr(clr),
  .sleep_mode(sleep_mode), .irq_o(irq_o), .wake_o(wake_o), .pu_o(pu_o),
  .pin_is_out(pin_is_out)
);

// File: tb/test_chg_notify.sv
module test_chg_notify;
  localparam int NP = 21;

  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [NP-1:0] pin_is_out = '0;
  logic sleep_mode = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NP-1:0] pu_o;
  logic irq_o, wake_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  chg_notify i_chg_notify (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_is_out(pin_is_out),
    .sleep_mode(sleep_mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pu_o(pu_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // {pins[20:0], enable[20:0], expected flag}
  localparam logic [42:0] VEC [8] = '{
    {21'h000001, 21'h000001, 1'b1},
    {21'h000000, 21'h000001, 1'b1},
    {21'h100000, 21'h000001, 1'b0},
    {21'h000000, 21'h100000, 1'b1},
    {21'h0F0F0F, 21'h100000, 1'b0},
    {21'h0F0F0E, 21'h000001, 1'b1},
    {21'h1F0F0E, 21'h010000, 1'b0},
    {21'h000000, 21'h1FFFFF, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwrite(logic [2:0] a, logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_en(logic [NP-1:0] e);
    bwrite(3'd0, e[15:0]);
    bwrite(3'd1, {11'd0, e[20:16]});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    logic [NP-1:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 wake", wake_o, 0);
    chk("R1 pu", pu_o, 0);
    for (int a = 0; a < 5; a++) begin
      bread(3'(a), rd);
      chk("R1 reg", rd, 0);
    end

    // R2 register layout
    bwrite(3'd1, 16'hFFFF);
    bread(3'd1, rd);
    chk("R2 en hi width", rd, 16'h001F);
    bwrite(3'd0, 16'hA5C3);
    bread(3'd0, rd);
    chk("R2 en lo", rd, 16'hA5C3);
    bwrite(3'd3, 16'hFFEA);
    bread(3'd3, rd);
    chk("R2 pu hi", rd, 16'h000A);

    // R8 pull-up gating
    bwrite(3'd2, 16'h00FF);
    bwrite(3'd3, 16'h001F);
    pin_is_out = 21'h0000F0;
    #1;
    chk("R8 pu gate", pu_o, 21'h1F000F);
    pin_is_out = 21'h1FFFFF;
    #1;
    chk("R8 all out", pu_o, 0);
    pin_is_out = '0;
    #1;
    chk("R8 all in", pu_o, 21'h1F00FF);

    // table walk: R3 rising, R4 falling, R5 masking
    cur = '0;
    pin_i = cur;
    set_en('0);
    repeat (3) @(negedge clk);
    bwrite(3'd4, 16'h0001);
    for (int i = 0; i < 8; i++) begin
      logic [NP-1:0] np, en;
      logic ex, calc;
      np = VEC[i][42:22];
      en = VEC[i][21:1];
      ex = VEC[i][0];
      calc = |((np ^ cur) & en);
      set_en(en);
      bwrite(3'd4, 16'h0001);
      chk("R6 cleared before vector", irq_o, 0);
      pin_i = np;
      repeat (3) @(negedge clk);
      chk("R3 R4 R5 table", irq_o, 32'(ex));
      chk("R5 table model", 32'(calc), 32'(ex));
      cur = np;
    end

    // R3 exact latency: not set before the third edge
    bwrite(3'd4, 16'h0001);
    set_en(21'h000004);
    pin_i = 21'h000004;
    repeat (2) @(negedge clk);
    chk("R3 not early", irq_o, 0);
    @(negedge clk);
    chk("R3 third edge", irq_o, 1);

    // R6 writing zero keeps flag, writing one clears
    bwrite(3'd4, 16'h0000);
    chk("R6 zero write", irq_o, 1);
    bread(3'd4, rd);
    chk("R2 status bit", rd, 16'h0001);
    bwrite(3'd4, 16'h0001);
    chk("R6 clear", irq_o, 0);

    // R5 enable after earlier change -> no flag
    set_en('0);
    pin_i = 21'h000104;
    repeat (4) @(negedge clk);
    set_en(21'h000100);
    repeat (3) @(negedge clk);
    chk("R5 late enable", irq_o, 0);

    // R7 change collides with clear
    pin_i = 21'h000004;
    repeat (3) @(negedge clk);
    chk("R7 preset", irq_o, 1);
    pin_i = 21'h000104;
    repeat (2) @(negedge clk);
    bwrite(3'd4, 16'h0001);
    chk("R7 set wins", irq_o, 1);
    bwrite(3'd4, 16'h0001);
    chk("R7 later clear", irq_o, 0);

    // R9 R10 R11 sleep path with clock stopped
    chk("R11 awake", wake_o, 0);
    sleep_mode = 1'b1;
    @(negedge clk);
    clk_run = 1'b0;
    #30;
    pin_i = 21'h000004;          // pin 8 is disabled? no: pin 8 enabled
    #5;
    chk("R9 enabled wake", wake_o, 1);
    chk("R10 no flag without clock", irq_o, 0);
    pin_i = 21'h000104;
    #5;
    chk("R9 back to latched", wake_o, 0);
    pin_i = 21'h000105;          // pin 0 disabled
    #5;
    chk("R9 masked no wake", wake_o, 0);
    pin_i = 21'h000005;          // pin 8 enabled, differs
    #5;
    chk("R9 wake again", wake_o, 1);
    clk_run = 1'b1;
    @(negedge clk);
    chk("R10 flag on resume", irq_o, 1);
    repeat (3) @(negedge clk);
    chk("R10 wake held", wake_o, 1);
    sleep_mode = 1'b0;
    #1;
    chk("R11 wake off", wake_o, 0);
    repeat (2) @(negedge clk);
    bwrite(3'd4, 16'h0001);
    chk("R6 final clear", irq_o, 0);

    finish_run();
  end
endmodule